// File: doc/BRIEF.md
# Configurable Interrupt Request Capture

This block is the input stage of an interrupt controller. It watches a bank of interrupt request lines and keeps one pending bit per line. Each line has its own trigger mode and polarity. A level-mode line is pending for as long as its input sits at the chosen polarity. An edge-mode line latches pending on a transition to that polarity and stays pending until something clears it.

Software reaches the configuration through a small byte-wide register window. The window holds the trigger modes, the polarities and the mask. Writes to the pending bytes are commands, not plain data: one write can clear a whole byte, or set or clear a single line.

Two inputs come from logic further down the chain. The acknowledge logic sends per-line clear pulses. The counter logic sends a suppress vector that marks lines it has taken over. The pending and mask vectors go out to a separate priority resolver.

Top module: `irq_capture`

## Requirements
- R1: Reset state. After synchronous reset every line is in level mode (mode bit 1), every polarity bit is 0, no line is pending and every mask bit is 1 (1 = masked). The synchronizer resets to all ones, so idle-high lines are not pending after reset.
- R2: Level mode. A level-mode line that is not suppressed is pending while its synchronized input equals its polarity bit. Its pending bit clears once the input differs from the polarity bit.
- R3: Edge mode. A line in edge mode (mode bit 0) that is not suppressed becomes pending when its synchronized input changes to the polarity value. A later change of the input does not clear the pending bit; only a command write or an acknowledge pulse does.
- R4: Configuration re-check. In the cycle after any write to a mode byte or a polarity byte, every line that is now in level mode and whose input matches its polarity becomes pending. This applies to suppressed lines too.
- R5: Clear-byte command. A write to a pending byte with bit 6 set clears all eight pending bits of that byte, whatever bit 7 holds.
- R6: Set command. A write to a pending byte with bit 6 clear and bit 7 set sets the line in that byte selected by bits 2:0.
- R7: Clear command. A write to a pending byte with bits 6 and 7 both clear clears the line in that byte selected by bits 2:0.
- R8: Suppress. A line whose suppress bit is 1 ignores its external input. Its pending bit keeps its value against input changes.
- R9: Acknowledge. A 1 on `ack_clr[i]` clears pending bit i at the next edge. If a pending command write lands in the same cycle, the command decides the bit's value.
- R10: Register window. Byte addresses 0/1 hold the mode low/high bytes, 2/3 the polarity bytes, 4/5 the pending bytes and 6/7 the mask bytes. `reg_rdata` returns the addressed byte combinationally, and a write changes only the addressed byte.
- R11: Mask. Mask writes appear on `mask_o` after the write edge. Masking has no effect on the pending bits.
- R12: Latency. An input change is first seen in the pending register at the third rising edge after it is applied: two synchronizer stages, then the pending register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | LINES | Asynchronous interrupt request inputs |
| ack_clr | input | LINES | Per-line pending clear pulses from acknowledge logic |
| suppress | input | LINES | Lines taken by counters; their external input is ignored |
| reg_wr | input | 1 | Register byte write strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the addressed byte |
| pend_o | output | LINES | Pending vector |
| mask_o | output | LINES | Mask vector (1 = masked) |

## Verification
Two sources can act on the same pending bit in one cycle: an acknowledge clear pulse and a pending-byte command write. The bench provokes this by driving `ack_clr` for a line in the same cycle as a set command to that line. It then checks that the bit reads as set, as the command dictates. A second collision is between the continuous level re-evaluation and a command on a level line. The cycle-by-cycle reference model applies the sources in the required order, and its result is compared with the design on every clock.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int BYTE_W    = 8;
    localparam int REG_COUNT = 4;

    // register groups in address order; each group spans LINES/8 bytes
    typedef enum logic [1:0] {
        SEL_TRIG = 2'd0,
        SEL_POL  = 2'd1,
        SEL_PEND = 2'd2,
        SEL_MASK = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic       clr_byte;
        logic       set_bit;
        logic [2:0] idx;
    } pend_cmd_t;

    function automatic pend_cmd_t decode_cmd(input logic [BYTE_W-1:0] d);
        pend_cmd_t c;
        c.clr_byte = d[6];
        c.set_bit  = d[7];
        c.idx      = d[2:0];
        return c;
    endfunction

endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] sync_q,
    output logic [W-1:0] prev_q
);
    // chain[STAGES-1] is the synchronized value, chain[STAGES] the prior sample
    logic [STAGES:0][W-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '1;
        end else begin
            chain[0] <= din;
            for (int s = 1; s <= STAGES; s++) begin
                chain[s] <= chain[s-1];
            end
        end
    end

    assign sync_q = chain[STAGES-1];
    assign prev_q = chain[STAGES];
endmodule

// File: rtl/irqc_cfg.sv
module irqc_cfg #(
    parameter int LINES  = 16,
    parameter int NBYTES = LINES / 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NBYTES-1:0] wr_trig,
    input  logic [NBYTES-1:0] wr_pol,
    input  logic [NBYTES-1:0] wr_mask,
    input  logic [7:0]       wdata,
    output logic [LINES-1:0] trig_q,
    output logic [LINES-1:0] pol_q,
    output logic [LINES-1:0] mask_q,
    output logic             touched_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            trig_q    <= '1;
            pol_q     <= '0;
            mask_q    <= '1;
            touched_q <= 1'b0;
        end else begin
            for (int b = 0; b < NBYTES; b++) begin
                if (wr_trig[b]) trig_q[b*8 +: 8] <= wdata;
                if (wr_pol[b])  pol_q[b*8 +: 8]  <= wdata;
                if (wr_mask[b]) mask_q[b*8 +: 8] <= wdata;
            end
            touched_q <= (|wr_trig) || (|wr_pol);
        end
    end
endmodule

// File: rtl/irqc_pend.sv
module irqc_pend
    import irqc_pkg::*;
#(
    parameter int LINES  = 16,
    parameter int NBYTES = LINES / 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LINES-1:0]  sync_in,
    input  logic [LINES-1:0]  prev_in,
    input  logic [LINES-1:0]  trig,
    input  logic [LINES-1:0]  pol,
    input  logic [LINES-1:0]  suppress,
    input  logic [LINES-1:0]  ack_clr,
    input  logic              recheck,
    input  logic [NBYTES-1:0] cmd_wr,
    input  logic [7:0]        wdata,
    output logic [LINES-1:0]  pend_q
);
    logic [LINES-1:0] match;
    logic [LINES-1:0] ext_val;
    logic [LINES-1:0] after_ack;
    logic [LINES-1:0] pend_d;
    pend_cmd_t        cmd;

    assign cmd = decode_cmd(wdata);

    genvar i;
    generate
        for (i = 0; i < LINES; i++) begin : g_line
            logic edge_hit;
            logic base;
            assign match[i] = ~(sync_in[i] ^ pol[i]);
            assign edge_hit = match[i] & (sync_in[i] ^ prev_in[i]);
            assign ext_val[i] = trig[i] ? match[i] : (pend_q[i] | edge_hit);
            assign base = (suppress[i] ? pend_q[i] : ext_val[i])
                        | (recheck & trig[i] & match[i]);
            assign after_ack[i] = base & ~ack_clr[i];
        end
    endgenerate

    // command writes are applied last and so override every other source
    always_comb begin
        pend_d = after_ack;
        for (int b = 0; b < NBYTES; b++) begin
            if (cmd_wr[b]) begin
                if (cmd.clr_byte) begin
                    pend_d[b*8 +: 8] = '0;
                end else begin
                    pend_d[b*8 + int'(cmd.idx)] = cmd.set_bit;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= pend_d;
    end
endmodule

// File: rtl/irq_capture.sv
module irq_capture
    import irqc_pkg::*;
#(
    parameter int LINES       = 16,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = $clog2(REG_COUNT * LINES / 8)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LINES-1:0]  irq_in,
    input  logic [LINES-1:0]  ack_clr,
    input  logic [LINES-1:0]  suppress,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic [LINES-1:0]  pend_o,
    output logic [LINES-1:0]  mask_o
);
    localparam int NBYTES = LINES / 8;
    localparam int BSEL_W = (NBYTES > 1) ? $clog2(NBYTES) : 1;

    logic [ADDR_W-1:0] sel_full;
    logic [ADDR_W-1:0] byte_full;
    reg_sel_e          sel;
    logic [BSEL_W-1:0] byte_idx;

    assign sel_full  = reg_addr / ADDR_W'(NBYTES);
    assign byte_full = reg_addr % ADDR_W'(NBYTES);
    assign sel       = reg_sel_e'(sel_full[1:0]);
    assign byte_idx  = byte_full[BSEL_W-1:0];

    logic [NBYTES-1:0] wr_trig, wr_pol, wr_pend, wr_mask;

    genvar b;
    generate
        for (b = 0; b < NBYTES; b++) begin : g_wen
            logic hit;
            assign hit        = reg_wr && (byte_idx == BSEL_W'(b));
            assign wr_trig[b] = hit && (sel == SEL_TRIG);
            assign wr_pol[b]  = hit && (sel == SEL_POL);
            assign wr_pend[b] = hit && (sel == SEL_PEND);
            assign wr_mask[b] = hit && (sel == SEL_MASK);
        end
    endgenerate

    logic [LINES-1:0] sync_v, prev_v;
    logic [LINES-1:0] trig_q, pol_q, mask_q, pend_q;
    logic             touched_q;

    irqc_sync #(.W(LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .din    (irq_in),
        .sync_q (sync_v),
        .prev_q (prev_v)
    );

    irqc_cfg #(.LINES(LINES), .NBYTES(NBYTES)) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .wr_trig   (wr_trig),
        .wr_pol    (wr_pol),
        .wr_mask   (wr_mask),
        .wdata     (reg_wdata),
        .trig_q    (trig_q),
        .pol_q     (pol_q),
        .mask_q    (mask_q),
        .touched_q (touched_q)
    );

    irqc_pend #(.LINES(LINES), .NBYTES(NBYTES)) u_pend (
        .clk      (clk),
        .rst      (rst),
        .sync_in  (sync_v),
        .prev_in  (prev_v),
        .trig     (trig_q),
        .pol      (pol_q),
        .suppress (suppress),
        .ack_clr  (ack_clr),
        .recheck  (touched_q),
        .cmd_wr   (wr_pend),
        .wdata    (reg_wdata),
        .pend_q   (pend_q)
    );

    logic [LINES-1:0] rd_src;
    always_comb begin
        unique case (sel)
            SEL_TRIG: rd_src = trig_q;
            SEL_POL:  rd_src = pol_q;
            SEL_PEND: rd_src = pend_q;
            default:  rd_src = mask_q;
        endcase
        reg_rdata = rd_src[int'(byte_idx)*8 +: 8];
    end

    assign pend_o = pend_q;
    assign mask_o = mask_q;
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
    parameter int LINES  = 16,
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [7:0]        reg_wdata,
    input logic [LINES-1:0]  ack_clr,
    input logic [LINES-1:0]  suppress,
    input logic [LINES-1:0]  trig,
    input logic [LINES-1:0]  pend_o,
    input logic [LINES-1:0]  mask_o
);
    localparam int NBYTES = LINES / 8;
    localparam logic [ADDR_W-1:0] PEND_LO = ADDR_W'(2 * NBYTES);
    localparam logic [ADDR_W-1:0] MASK_LO = ADDR_W'(3 * NBYTES);

    logic cfg_wr_q;
    always_ff @(posedge clk) begin
        if (rst) cfg_wr_q <= 1'b0;
        else     cfg_wr_q <= reg_wr && (reg_addr < PEND_LO);
    end

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (pend_o == '0) && (mask_o == '1));

    assert_edge_sticky_R3: assert property (@(posedge clk) disable iff (rst)
        (!reg_wr && ack_clr == '0) |=>
            ((~$past(trig) & $past(pend_o) & ~pend_o) == '0));

    assert_clr_byte_R5: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == PEND_LO && reg_wdata[6]) |=> (pend_o[7:0] == 8'h00));

    assert_set_bit_R6: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == PEND_LO && !reg_wdata[6] && reg_wdata[7])
            |=> pend_o[$past(reg_wdata[2:0])]);

    assert_suppress_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!reg_wr && ack_clr == '0 && !cfg_wr_q) |=>
            (((pend_o ^ $past(pend_o)) & $past(suppress)) == '0));

    assert_ack_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (!reg_wr && ack_clr != '0) |=> ((pend_o & $past(ack_clr)) == '0));

    assert_mask_write_R11: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == MASK_LO) |=> (mask_o[7:0] == $past(reg_wdata)));
endmodule

bind irq_capture irqc_checker #(.LINES(LINES), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .ack_clr   (ack_clr),
    .suppress  (suppress),
    .trig      (trig_q),
    .pend_o    (pend_o),
    .mask_o    (mask_o)
);

// File: tb/sim_irq_capture.sv
`timescale 1ns/1ps
module sim_irq_capture;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] irq_in = 16'hFFFF;
    logic [15:0] ack_clr = '0;
    logic [15:0] suppress = '0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [15:0] pend_o, mask_o;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2 clk = ~clk;   // 250 MHz

    irq_capture u0 (
        .clk(clk), .rst(rst), .irq_in(irq_in), .ack_clr(ack_clr),
        .suppress(suppress), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pend_o(pend_o), .mask_o(mask_o)
    );

    // behavioural reference model, updated at every rising edge
    logic [15:0] ms1, ms2, mprev, mtrig, mpol, mmask, mpend;
    bit          mtouch;

    always @(posedge clk) begin
        logic [15:0] np;
        if (rst) begin
            ms1 = '1; ms2 = '1; mprev = '1;
            mtrig = '1; mpol = '0; mmask = '1; mpend = '0; mtouch = 0;
        end else begin
            np = mpend;
            for (int i = 0; i < 16; i++) begin
                if (!suppress[i]) begin
                    if (mtrig[i]) np[i] = (ms2[i] == mpol[i]);
                    else if (ms2[i] == mpol[i] && ms2[i] != mprev[i]) np[i] = 1'b1;
                end
                if (mtouch && mtrig[i] && ms2[i] == mpol[i]) np[i] = 1'b1;
                if (ack_clr[i]) np[i] = 1'b0;
            end
            mtouch = 0;
            if (reg_wr) begin
                case (reg_addr)
                    3'd0: begin mtrig[7:0]  = reg_wdata; mtouch = 1; end
                    3'd1: begin mtrig[15:8] = reg_wdata; mtouch = 1; end
                    3'd2: begin mpol[7:0]   = reg_wdata; mtouch = 1; end
                    3'd3: begin mpol[15:8]  = reg_wdata; mtouch = 1; end
                    3'd4, 3'd5: begin
                        int base;
                        base = (reg_addr == 3'd5) ? 8 : 0;
                        if (reg_wdata[6]) begin
                            for (int k = 0; k < 8; k++) np[base+k] = 1'b0;
                        end else begin
                            np[base + int'(reg_wdata[2:0])] = reg_wdata[7];
                        end
                    end
                    3'd6: mmask[7:0]  = reg_wdata;
                    default: mmask[15:8] = reg_wdata;
                endcase
            end
            mprev = ms2; ms2 = ms1; ms1 = irq_in; mpend = np;
        end
    end

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // advance one clock; compare with the model just after the edge
    task automatic cyc();
        @(posedge clk);
        #1;
        if (!rst) begin
            check("MODEL pend", pend_o, mpend);
            check("MODEL mask", mask_o, mmask);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        cyc();
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
        reg_addr = a;
        #0.5;
        check(req, {8'h00, reg_rdata}, {8'h00, exp});
    endtask

    initial begin
        #(4 * 20000);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
        end
        $finish;
    end

    initial begin
        repeat (3) cyc();
        rst = 1'b0;
        cyc();
        // R1 reset state, read through the R10 window
        check("R1 pend", pend_o, 16'h0000);
        check("R1 mask", mask_o, 16'hFFFF);
        rd_chk("R1 trig lo", 3'd0, 8'hFF);
        rd_chk("R1 trig hi", 3'd1, 8'hFF);
        rd_chk("R1 pol lo", 3'd2, 8'h00);
        rd_chk("R1 pol hi", 3'd3, 8'h00);

        // R2 / R12: level line 3 driven to its polarity (0)
        irq_in[3] = 1'b0;
        cyc(); cyc();
        check("R12 not yet", pend_o, 16'h0000);
        cyc();
        check("R2 R12 level set", pend_o, 16'h0008);
        irq_in[3] = 1'b1;
        repeat (3) cyc();
        check("R2 level clear", pend_o, 16'h0000);

        // R3: line 1 in edge mode
        wr(3'd0, 8'hFD);
        irq_in[1] = 1'b0;
        repeat (3) cyc();
        check("R3 edge set", pend_o, 16'h0002);
        irq_in[1] = 1'b1;
        repeat (4) cyc();
        check("R3 edge sticky", pend_o, 16'h0002);
        wr(3'd4, 8'h01);
        check("R7 clear bit", pend_o, 16'h0000);

        // R6 / R5 on the high byte, all edge mode
        wr(3'd1, 8'h00);
        wr(3'd5, 8'h85);
        check("R6 set bit13", pend_o, 16'h2000);
        wr(3'd5, 8'h82);
        check("R6 set bit10", pend_o, 16'h2400);
        rd_chk("R10 pend hi read", 3'd5, 8'h24);
        wr(3'd5, 8'hC5);
        check("R5 clear byte", pend_o, 16'h0000);

        // R4 re-check on a suppressed line 9
        suppress[9] = 1'b1;
        wr(3'd3, 8'h02);
        cyc();
        check("R4 pol write edge line no set", pend_o, 16'h0000);
        irq_in[9] = 1'b1;
        wr(3'd1, 8'h02);
        cyc();
        check("R4 recheck sets", pend_o, 16'h0200);
        // R8: suppressed line ignores input
        irq_in[9] = 1'b0;
        repeat (4) cyc();
        check("R8 suppressed hold", pend_o, 16'h0200);

        // R9 acknowledge, then collision with a set command
        ack_clr[9] = 1'b1;
        cyc();
        ack_clr[9] = 1'b0;
        check("R9 ack clear", pend_o, 16'h0000);
        ack_clr[12] = 1'b1;
        wr(3'd5, 8'h84);
        ack_clr[12] = 1'b0;
        check("R9 command wins", pend_o, 16'h1000);
        ack_clr[12] = 1'b1;
        cyc();
        ack_clr[12] = 1'b0;
        check("R9 ack alone", pend_o, 16'h0000);

        // R11 mask, no effect on pending
        wr(3'd5, 8'h83);
        wr(3'd6, 8'h5A);
        wr(3'd7, 8'h3C);
        check("R11 mask out", mask_o, 16'h3C5A);
        check("R11 pend unaffected", pend_o, 16'h0800);
        rd_chk("R11 mask lo read", 3'd6, 8'h5A);

        // R10 byte isolation
        wr(3'd2, 8'h0F);
        rd_chk("R10 pol lo", 3'd2, 8'h0F);
        rd_chk("R10 pol hi kept", 3'd3, 8'h02);
        rd_chk("R10 trig lo kept", 3'd0, 8'hFD);
        repeat (5) cyc();

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule